// File: doc/BRIEF.md
# Store Completion Tracker

This block follows the stores of up to eight in-flight instruction blocks, each held in a frame. When a frame is allocated, the block header supplies two things: the number of stores the block will produce, and a mask that marks which 5-bit load/store IDs are stores. Store arrival events come in on several ports, one for local stores and others for arrivals that peer slices broadcast. Each event carries a frame number and an ID. For every frame the tracker keeps a sticky arrival bitmap and a counter of distinct arrivals. It raises a one-cycle completion pulse for the frame once the counter reaches the header's count.

A held-back load can ask whether every store below its own ID in its frame has arrived. The answer is combinational from the tracked state, so a deferred load can be released as soon as the answer goes high. Stores at or above the load's ID play no part in the answer. For that reason, loads that sit between the same two stores are released together and in no fixed order.

Top module: `store_done_tracker`

## Requirements
- R1: After reset no frame is active, `donePulse` is all zero and `qryAllPrior` is 0.
- R2: An allocation clears the frame's bitmap and counter and loads the header count and store mask. An allocation with a count of 0 pulses its `donePulse` bit in the cycle after the edge that follows the allocating edge.
- R3: An arrival on an active frame sets that ID's bit. When the count of distinct arrivals equals the header count, `donePulse[frame]` is high in the cycle after the edge that follows the edge sampling the completing arrival.
- R4: An arrival whose ID bit is already set does not add to the count, and neither does the same ID arriving on two ports in one cycle.
- R5: Each completion pulse lasts exactly one cycle and does not recur for further arrivals until the frame is allocated again. After reallocation the frame can complete again.
- R6: Arrivals naming a frame that is not active are dropped: there is no pulse and no query change.
- R7: If an allocation and an arrival for the same frame are sampled at the same edge, the allocation wins and the arrival is dropped.
- R8: `qryAllPrior` is 1 exactly when frame `qryFrame` is active and every ID below `qryLsid` that is set in the store mask has arrived. Bit i of the mask and bitmap stands for ID i. The answer reflects arrivals sampled up to the previous edge.
- R9: Arrivals with distinct IDs on different ports for the same frame in one cycle are all counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| allocValid | input | 1 | Allocate a frame this cycle |
| allocFrame | input | 3 | Frame being allocated |
| allocCount | input | 6 | Expected store count from the header |
| allocStoreMask | input | 32 | Header mask, bit i set when ID i is a store |
| arrValid | input | 2 | Arrival valid per port (port 0 local, port 1 remote) |
| arrFrame | input | 2x3 | Arrival frame per port |
| arrLsid | input | 2x5 | Arrival store ID per port |
| qryFrame | input | 3 | Frame of the deferred load |
| qryLsid | input | 5 | ID of the deferred load |
| qryAllPrior | output | 1 | All earlier stores of that frame have arrived |
| donePulse | output | 8 | One-cycle completion pulse per frame |

## Verification
The query answer is combinational, so it is due in the same cycle as the query inputs and reflects every arrival sampled at or before the previous edge. A completion pulse is due one edge later than the state change that causes it. That means two edges after the completing arrival or a zero-count allocation is sampled, and it lasts for exactly one cycle. The bench drives inputs a quarter period after the rising edge. It compares both outputs against a behavioural model every cycle after the falling edge. Its directed checks sample at the exact cycle each result is due, and again in the cycle after, to catch pulses that are early, late or stretched.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  localparam int FRAMES  = 8;
  localparam int PORTS   = 2;
  localparam int ID_W    = 5;
  localparam int SLOTS   = 1 << ID_W;
  localparam int FRAME_W = $clog2(FRAMES);
  localparam int CNT_W   = $clog2(SLOTS + 1);

  // Strobes from control to datapath.
  typedef struct packed {
    logic               clrEn;
    logic [FRAME_W-1:0] clrFrame;
    logic [PORTS-1:0]   takeArr;
  } strobes_t;
endpackage

// File: rtl/sdt_ctrl.sv
module sdt_ctrl
  import sdt_pkg::*;
#(
  parameter int NUM_FRAMES = FRAMES,
  parameter int NUM_PORTS  = PORTS,
  localparam int FW        = $clog2(NUM_FRAMES)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           allocValid,
  input  logic [FW-1:0]                  allocFrame,
  input  logic [NUM_PORTS-1:0]           arrValid,
  input  logic [NUM_PORTS-1:0][FW-1:0]   arrFrame,
  input  logic [NUM_FRAMES-1:0]          cntMet,
  output strobes_t                       strb,
  output logic [NUM_FRAMES-1:0]          activeVec,
  output logic [NUM_FRAMES-1:0]          donePulse
);
  logic [NUM_FRAMES-1:0] activeQ;
  logic [NUM_FRAMES-1:0] reportedQ;
  logic [NUM_FRAMES-1:0] doneNow;
  logic [NUM_FRAMES-1:0] allocHit;

  assign activeVec = activeQ;

  always_comb begin
    strb.clrEn    = allocValid;
    strb.clrFrame = allocFrame;
    for (int p = 0; p < NUM_PORTS; p++) begin
      // Drop arrivals to idle frames and to a frame being reallocated.
      strb.takeArr[p] = arrValid[p] && activeQ[arrFrame[p]] &&
                        !(allocValid && (allocFrame == arrFrame[p]));
    end
  end

  genvar f;
  generate
    for (f = 0; f < NUM_FRAMES; f++) begin : g_frame
      assign allocHit[f] = allocValid && (allocFrame == FW'(f));
      assign doneNow[f]  = activeQ[f] && !reportedQ[f] && cntMet[f] && !allocHit[f];

      assert_single_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
        donePulse[f] |=> !donePulse[f]);
      assert_pulse_marks_frame_R3: assert property (@(posedge clk) disable iff (!rstN)
        donePulse[f] |-> (activeQ[f] && reportedQ[f]));
      assert_idle_no_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
        !activeQ[f] |=> !donePulse[f]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ   <= '0;
      reportedQ <= '0;
      donePulse <= '0;
    end else begin
      donePulse <= doneNow;
      for (int i = 0; i < NUM_FRAMES; i++) begin
        if (allocHit[i]) begin
          activeQ[i]   <= 1'b1;
          reportedQ[i] <= 1'b0;
        end else if (doneNow[i]) begin
          reportedQ[i] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdt_datapath.sv
module sdt_datapath
  import sdt_pkg::*;
#(
  parameter int NUM_FRAMES = FRAMES,
  parameter int NUM_PORTS  = PORTS,
  parameter int LSID_W     = ID_W,
  localparam int FW        = $clog2(NUM_FRAMES),
  localparam int NSLOT     = 1 << LSID_W,
  localparam int CW        = $clog2(NSLOT + 1)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  strobes_t                           strb,
  input  logic [CW-1:0]                      allocCount,
  input  logic [NSLOT-1:0]                   allocStoreMask,
  input  logic [NUM_PORTS-1:0][FW-1:0]       arrFrame,
  input  logic [NUM_PORTS-1:0][LSID_W-1:0]   arrLsid,
  input  logic [NUM_FRAMES-1:0]              activeVec,
  input  logic [FW-1:0]                      qryFrame,
  input  logic [LSID_W-1:0]                  qryLsid,
  output logic [NUM_FRAMES-1:0]              cntMet,
  output logic                               qryAllPrior
);
  logic [NSLOT-1:0] arrivedQ [NUM_FRAMES];
  logic [NSLOT-1:0] storeMaskQ [NUM_FRAMES];
  logic [CW-1:0]    expectQ [NUM_FRAMES];
  logic [CW-1:0]    countQ [NUM_FRAMES];
  logic [NSLOT-1:0] freshBits [NUM_FRAMES];
  logic [NSLOT-1:0] belowMask;
  logic [NSLOT-1:0] pendingBits;

  function automatic logic [CW-1:0] onesOf(input logic [NSLOT-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < NSLOT; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  // Bits that are newly arriving this cycle, per frame; duplicates fold away.
  always_comb begin
    for (int f = 0; f < NUM_FRAMES; f++) begin
      freshBits[f] = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (strb.takeArr[p] && (arrFrame[p] == FW'(f)))
          freshBits[f] = freshBits[f] | (NSLOT'(1) << arrLsid[p]);
      end
      freshBits[f] = freshBits[f] & ~arrivedQ[f];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int f = 0; f < NUM_FRAMES; f++) begin
        arrivedQ[f]   <= '0;
        storeMaskQ[f] <= '0;
        expectQ[f]    <= '0;
        countQ[f]     <= '0;
      end
    end else begin
      for (int f = 0; f < NUM_FRAMES; f++) begin
        if (strb.clrEn && (strb.clrFrame == FW'(f))) begin
          arrivedQ[f]   <= '0;
          storeMaskQ[f] <= allocStoreMask;
          expectQ[f]    <= allocCount;
          countQ[f]     <= '0;
        end else begin
          arrivedQ[f] <= arrivedQ[f] | freshBits[f];
          countQ[f]   <= countQ[f] + onesOf(freshBits[f]);
        end
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_FRAMES; g++) begin : g_cmp
      assign cntMet[g] = (countQ[g] == expectQ[g]);

      assert_bits_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
        !(strb.clrEn && (strb.clrFrame == FW'(g))) |=>
          ((arrivedQ[g] & $past(arrivedQ[g])) == $past(arrivedQ[g])));
      assert_count_distinct_R4: assert property (@(posedge clk) disable iff (!rstN)
        countQ[g] == onesOf(arrivedQ[g]));
      assert_alloc_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
        (strb.clrEn && (strb.clrFrame == FW'(g))) |=> (countQ[g] == '0 && arrivedQ[g] == '0));
    end
  endgenerate

  // Query: stores strictly below the load's ID that are still missing.
  assign belowMask   = (NSLOT'(1) << qryLsid) - NSLOT'(1);
  assign pendingBits = storeMaskQ[qryFrame] & ~arrivedQ[qryFrame] & belowMask;
  assign qryAllPrior = activeVec[qryFrame] && (pendingBits == '0);

  assert_lowest_id_free_R8: assert property (@(posedge clk) disable iff (!rstN)
    (activeVec[qryFrame] && qryLsid == '0) |-> qryAllPrior);
endmodule

// File: rtl/store_done_tracker.sv
module store_done_tracker
  import sdt_pkg::*;
#(
  parameter int NUM_FRAMES = FRAMES,
  parameter int NUM_PORTS  = PORTS,
  parameter int LSID_W     = ID_W,
  localparam int FW        = $clog2(NUM_FRAMES),
  localparam int NSLOT     = 1 << LSID_W,
  localparam int CW        = $clog2(NSLOT + 1)
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             allocValid,
  input  logic [FW-1:0]                    allocFrame,
  input  logic [CW-1:0]                    allocCount,
  input  logic [NSLOT-1:0]                 allocStoreMask,
  input  logic [NUM_PORTS-1:0]             arrValid,
  input  logic [NUM_PORTS-1:0][FW-1:0]     arrFrame,
  input  logic [NUM_PORTS-1:0][LSID_W-1:0] arrLsid,
  input  logic [FW-1:0]                    qryFrame,
  input  logic [LSID_W-1:0]                qryLsid,
  output logic                             qryAllPrior,
  output logic [NUM_FRAMES-1:0]            donePulse
);
  strobes_t              strb;
  logic [NUM_FRAMES-1:0] cntMet;
  logic [NUM_FRAMES-1:0] activeVec;

  initial begin
    if (NUM_FRAMES != FRAMES || NUM_PORTS != PORTS || LSID_W != ID_W)
      $error("store_done_tracker: parameters disagree with sdt_pkg");
  end

  sdt_ctrl #(.NUM_FRAMES(NUM_FRAMES), .NUM_PORTS(NUM_PORTS)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .allocValid(allocValid), .allocFrame(allocFrame),
    .arrValid(arrValid), .arrFrame(arrFrame),
    .cntMet(cntMet), .strb(strb), .activeVec(activeVec), .donePulse(donePulse)
  );

  sdt_datapath #(.NUM_FRAMES(NUM_FRAMES), .NUM_PORTS(NUM_PORTS), .LSID_W(LSID_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .allocCount(allocCount), .allocStoreMask(allocStoreMask),
    .arrFrame(arrFrame), .arrLsid(arrLsid), .activeVec(activeVec),
    .qryFrame(qryFrame), .qryLsid(qryLsid),
    .cntMet(cntMet), .qryAllPrior(qryAllPrior)
  );
endmodule

// File: tb/store_done_tracker_tb_top.sv
module store_done_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            allocValid = 1'b0;
  logic [2:0]      allocFrame = '0;
  logic [5:0]      allocCount = '0;
  logic [31:0]     allocStoreMask = '0;
  logic [1:0]      arrValid = '0;
  logic [1:0][2:0] arrFrame = '0;
  logic [1:0][4:0] arrLsid = '0;
  logic [2:0]      qryFrame = '0;
  logic [4:0]      qryLsid = '0;
  logic            qryAllPrior;
  logic [7:0]      donePulse;

  int checkCnt = 0;
  int failCnt = 0;
  int cycles = 0;
  bit finished = 0;

  // Behavioural reference state
  bit [31:0] mBits [8];
  bit [31:0] mMask [8];
  int        mCnt [8];
  int        mExp [8];
  bit        mAct [8];
  bit        mRep [8];
  logic [7:0] mPulse = '0;

  store_done_tracker dut_i (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocFrame(allocFrame),
    .allocCount(allocCount), .allocStoreMask(allocStoreMask), .arrValid(arrValid),
    .arrFrame(arrFrame), .arrLsid(arrLsid), .qryFrame(qryFrame), .qryLsid(qryLsid),
    .qryAllPrior(qryAllPrior), .donePulse(donePulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit refQuery(input int f, input int l);
    bit [31:0] below;
    below = (32'd1 << l) - 32'd1;
    return mAct[f] && ((mMask[f] & ~mBits[f] & below) == 32'd0);
  endfunction

  // Reference model: updates at each rising edge from the sampled inputs.
  always @(posedge clk) begin
    if (!rstN) begin
      for (int f = 0; f < 8; f++) begin
        mBits[f] = '0; mMask[f] = '0; mCnt[f] = 0; mExp[f] = 0; mAct[f] = 0; mRep[f] = 0;
      end
      mPulse = '0;
    end else begin
      for (int f = 0; f < 8; f++) begin
        mPulse[f] = mAct[f] && !mRep[f] && (mCnt[f] == mExp[f]) &&
                    !(allocValid && allocFrame == 3'(f));
        if (mPulse[f]) mRep[f] = 1;
      end
      for (int p = 0; p < 2; p++) begin
        if (arrValid[p] && mAct[arrFrame[p]] && !(allocValid && allocFrame == arrFrame[p]) &&
            !mBits[arrFrame[p]][arrLsid[p]]) begin
          mBits[arrFrame[p]][arrLsid[p]] = 1'b1;
          mCnt[arrFrame[p]]++;
        end
      end
      if (allocValid) begin
        mAct[allocFrame] = 1; mRep[allocFrame] = 0; mBits[allocFrame] = '0;
        mCnt[allocFrame] = 0; mExp[allocFrame] = allocCount; mMask[allocFrame] = allocStoreMask;
      end
    end
  end

  // Every-cycle comparison after the falling edge (R3 R5 pulses, R8 query).
  always begin
    @(posedge clk);
    #(CLK_PERIOD*3/4);
    if (!finished) begin
      check(donePulse === mPulse, "R3 R5 model donePulse", donePulse, mPulse);
      check(qryAllPrior === refQuery(qryFrame, qryLsid), "R8 model qryAllPrior",
            qryAllPrior, refQuery(qryFrame, qryLsid));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      failCnt++; checkCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic doAlloc(input int f, input int c, input logic [31:0] m);
    allocValid = 1; allocFrame = 3'(f); allocCount = 6'(c); allocStoreMask = m;
    tick();
    allocValid = 0;
  endtask

  task automatic doArr(input int f, input int l);
    arrValid = 2'b01; arrFrame[0] = 3'(f); arrLsid[0] = 5'(l);
    tick();
    arrValid = '0;
  endtask

  task automatic doArr2(input int f, input int l0, input int l1);
    arrValid = 2'b11; arrFrame[0] = 3'(f); arrFrame[1] = 3'(f);
    arrLsid[0] = 5'(l0); arrLsid[1] = 5'(l1);
    tick();
    arrValid = '0;
  endtask

  task automatic qry(input int f, input int l, input bit exp, input string tag);
    qryFrame = 3'(f); qryLsid = 5'(l);
    #1;
    check(qryAllPrior === exp, tag, qryAllPrior, exp);
  endtask

  task automatic pulseIs(input logic [7:0] exp, input string tag);
    check(donePulse === exp, tag, donePulse, exp);
  endtask

  initial begin
    repeat (3) tick();
    qry(0, 0, 0, "R1 reset query");
    pulseIs(8'h00, "R1 reset pulses");
    rstN = 1;
    tick();

    // R2: zero-count allocation completes immediately
    doAlloc(2, 0, 32'h0);
    pulseIs(8'h00, "R2 not before due cycle");
    tick(); pulseIs(8'h04, "R2 zero-count pulse");
    tick(); pulseIs(8'h00, "R2 pulse ends");

    // R8: query against header mask (stores at IDs 2,5,9)
    doAlloc(1, 3, 32'h0000_0224);
    qry(1, 3, 0, "R8 store 2 pending");
    qry(1, 2, 1, "R8 no store below 2");
    qry(1, 0, 1, "R8 lowest ID");
    doArr(1, 5);
    qry(1, 6, 0, "R8 store 2 still pending");
    // R4: same ID on both ports counts once
    doArr2(1, 2, 2);
    qry(1, 6, 1, "R8 stores 2 and 5 arrived");
    qry(1, 9, 1, "R8 loads between stores released");
    qry(1, 10, 0, "R8 store 9 pending");
    tick(); pulseIs(8'h00, "R4 dual-port duplicate not double counted");
    doArr(1, 5);
    tick(); pulseIs(8'h00, "R4 repeated arrival not counted");
    // R3: completing arrival
    doArr(1, 9);
    pulseIs(8'h00, "R3 not before due cycle");
    tick(); pulseIs(8'h02, "R3 completion pulse");
    tick(); pulseIs(8'h00, "R5 one cycle only");
    doArr(1, 20);
    tick(); tick(); pulseIs(8'h00, "R5 no repeat on extra arrival");

    // R6: arrivals to an idle frame
    doArr(4, 3);
    tick(); pulseIs(8'h00, "R6 idle frame no pulse");
    qry(4, 31, 0, "R6 idle frame query");

    // R7: allocation beats same-cycle arrival
    arrValid = 2'b10; arrFrame[1] = 3'd6; arrLsid[1] = 5'd0;
    doAlloc(6, 1, 32'h1);
    arrValid = '0;
    qry(6, 1, 0, "R7 arrival dropped");
    tick(); pulseIs(8'h00, "R7 no completion");
    doArr(6, 0);
    tick(); pulseIs(8'h40, "R7 completes after real arrival");

    // R9: two distinct IDs on two ports in one cycle
    doAlloc(3, 2, 32'h0000_000a);
    doArr2(3, 1, 3);
    tick(); pulseIs(8'h08, "R9 both ports counted");

    // R5: reallocation rearms completion
    doAlloc(1, 1, 32'h1);
    doArr(1, 0);
    tick(); pulseIs(8'h02, "R5 pulse after reallocation");
    tick();

    // Random traffic, compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] m;
      m = $urandom & 32'h0000_00ff;
      allocValid = (($urandom % 10) == 0);
      allocFrame = 3'($urandom);
      allocStoreMask = m;
      allocCount = (($urandom % 4) == 0) ? 6'($urandom % 9) : 6'($countones(m));
      arrValid = 2'($urandom);
      arrFrame[0] = 3'($urandom); arrFrame[1] = 3'($urandom);
      arrLsid[0] = 5'($urandom % 9); arrLsid[1] = 5'($urandom % 9);
      qryFrame = 3'($urandom); qryLsid = 5'($urandom % 12);
      tick();
    end
    allocValid = 0; arrValid = '0;
    tick(); tick();

    finished = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule